// File: doc/BRIEF.md
# Stereo Disparity Winner Selection with Uniqueness Test

This block sits at the end of a semi-global stereo matching pipeline. For every pixel it receives a whole vector of aggregated matching costs at once, one cost per candidate disparity. It picks the disparity whose cost is lowest and reports that index as the pixel's disparity. A larger index means the object is closer to the cameras. The index is only reported when the winner is clearly better than the best competitor that lies outside its immediate neighbourhood. Otherwise the pixel is marked unreliable.

Pixels arrive as a stream. A valid strobe qualifies each beat, and start-of-line and end-of-line flags mark row boundaries. The output is a stream of the same shape: the flags are delayed by exactly the pipeline latency, so each output beat lines up with its input beat. In every row, the first columns have no complete search range. There are as many of them as there are disparity levels, and they are forced to zero, so the output row keeps the full input width.

The uniqueness threshold is a 7-bit runtime input. It is sampled with each pixel, so it may change at any time without disturbing pixels already in flight. The number of disparity levels and the cost width are elaboration parameters.

Top module: `disp_select`

## Requirements
- R1: For a pixel outside the zero-filled columns that passes the uniqueness test, `out_disp` equals the index of the smallest cost in `in_costs`. Level i occupies bits [i*COST_W +: COST_W].
- R2: When several levels share the smallest cost, the lowest index among them is chosen.
- R3: The runner-up cost used by the uniqueness test is the minimum over all levels whose index differs from the winner's index by more than 1. The two direct neighbours of the winner never count as runner-up.
- R4: A pixel passes the uniqueness test only when min*(100+U) < runner_up*100. U is `uniq_thr`, and any value above 100 is treated as 100. A larger U therefore never turns a failing pixel into a passing one.
- R5: A failing pixel outputs `out_disp` with all bits set and `out_invalid` = 1. A passing pixel, and every zero-filled pixel, has `out_invalid` = 0. `out_disp` is $clog2(LEVELS)+1 bits wide, so the all-ones code never equals a real index.
- R6: Within a row, the valid pixels in columns 0 to LEVELS-1 output `out_disp` = 0 and `out_invalid` = 0, whatever their costs are.
- R7: A valid beat with `in_sol` = 1 is column 0. Each further valid beat advances the column by one. Beats with `in_valid` = 0 neither advance the column nor produce output, whatever their other inputs carry.
- R8: Each valid input beat produces exactly one output beat, 2*$clog2(LEVELS)+2 cycles later. `out_sol` and `out_eol` are the input flags of that beat.
- R9: While `rst_n` is low, all outputs are 0.
- R10: LEVELS is accepted from 8 to 128 inclusive. Values outside that range stop elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat qualifier |
| in_sol | input | 1 | First pixel of a row |
| in_eol | input | 1 | Last pixel of a row |
| in_costs | input | LEVELS*COST_W | Aggregated costs, level i in bits [i*COST_W +: COST_W] |
| uniq_thr | input | 7 | Uniqueness threshold in percent, values above 100 act as 100 |
| out_valid | output | 1 | Output beat qualifier |
| out_sol | output | 1 | Delayed start-of-line |
| out_eol | output | 1 | Delayed end-of-line |
| out_disp | output | $clog2(LEVELS)+1 | Selected disparity, 0 in fill columns, all ones when unreliable |
| out_invalid | output | 1 | Pixel failed the uniqueness test |

## Verification
The winner and runner-up checks inside the design assume that no real cost equals the all-ones value of COST_W bits. That value is reserved as the masking value for excluded neighbours. The bench therefore draws costs no higher than 1023 in a 12-bit field. The column checks assume that a row starts with a valid start-of-line beat. Every generated row opens that way, and its bubbles carry random cost data with all flags low.

// File: rtl/dsel_pkg.sv
package dsel_pkg;

  localparam int THR_W   = 7;
  localparam int THR_CAP = 100;

  typedef struct packed {
    logic             vld;
    logic             sol;
    logic             eol;
    logic             zf;    // pixel lies in the zero-filled columns
    logic [THR_W-1:0] thr;
  } dsel_ctrl_t;

  // Threshold saturates at the percentage cap
  function automatic logic [THR_W-1:0] clamp_thr(input logic [THR_W-1:0] t);
    return (t > THR_W'(THR_CAP)) ? THR_W'(THR_CAP) : t;
  endfunction

  // Winner is distinct when mn*(100+U) < sec*100
  function automatic logic uniq_ok(input logic [31:0] mn, input logic [31:0] sec,
                                   input logic [THR_W-1:0] thr);
    logic [47:0] lhs;
    logic [47:0] rhs;
    lhs = 48'(mn) * (48'd100 + 48'(clamp_thr(thr)));
    rhs = 48'(sec) * 48'd100;
    return lhs < rhs;
  endfunction

  // Level index within one step of the winner
  function automatic logic is_near(input logic [7:0] a, input logic [7:0] b);
    return (a == b) || (a == b + 8'd1) || (b == a + 8'd1);
  endfunction

endpackage

// File: rtl/dsel_min_tree.sv
module dsel_min_tree #(
  parameter int N  = 8,
  parameter int W  = 16,
  parameter int IW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*W-1:0] vals_i,
  output logic [W-1:0]   min_o,
  output logic [IW-1:0]  idx_o
);

  localparam int D = $clog2(N);
  localparam int P = 1 << D;

  // leaves are combinational, every internal node is one register stage
  logic [W-1:0]  lv [P];
  logic [IW-1:0] li [P];
  logic [W-1:0]  nv [1:P-1];
  logic [IW-1:0] ni [1:P-1];

  generate
    for (genvar i = 0; i < P; i++) begin : g_leaf
      if (i < N) begin : g_real
        assign lv[i] = vals_i[i*W +: W];
      end else begin : g_pad
        assign lv[i] = {W{1'b1}};
      end
      assign li[i] = IW'(i);
    end

    for (genvar k = 1; k < P; k++) begin : g_node
      logic [W-1:0]  av, bv;
      logic [IW-1:0] ai, bi;
      if (2*k >= P) begin : g_from_leaf
        assign av = lv[2*k-P];
        assign ai = li[2*k-P];
        assign bv = lv[2*k+1-P];
        assign bi = li[2*k+1-P];
      end else begin : g_from_node
        assign av = nv[2*k];
        assign ai = ni[2*k];
        assign bv = nv[2*k+1];
        assign bi = ni[2*k+1];
      end
      // left child holds the lower indices: it keeps ties
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          nv[k] <= '0;
          ni[k] <= '0;
        end else if (bv < av) begin
          nv[k] <= bv;
          ni[k] <= bi;
        end else begin
          nv[k] <= av;
          ni[k] <= ai;
        end
      end
    end
  endgenerate

  assign min_o = nv[1];
  assign idx_o = ni[1];

endmodule

// File: rtl/dsel_delay.sv
module dsel_delay #(
  parameter int W     = 8,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] sr [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) sr[i] <= '0;
    end else begin
      sr[0] <= d_i;
      for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
    end
  end

  assign q_o = sr[DEPTH-1];

endmodule

// File: rtl/disp_select.sv
module disp_select
  import dsel_pkg::*;
#(
  parameter int LEVELS = 64,
  parameter int COST_W = 16,
  parameter int COL_W  = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       in_valid,
  input  logic                       in_sol,
  input  logic                       in_eol,
  input  logic [LEVELS*COST_W-1:0]   in_costs,
  input  logic [6:0]                 uniq_thr,
  output logic                       out_valid,
  output logic                       out_sol,
  output logic                       out_eol,
  output logic [$clog2(LEVELS):0]    out_disp,
  output logic                       out_invalid
);

  localparam int D      = $clog2(LEVELS);
  localparam int IW     = D + 1;
  localparam int VEC_W  = LEVELS * COST_W;
  localparam int CTRL_W = $bits(dsel_ctrl_t);

  // R10
  generate
    if (LEVELS < 8 || LEVELS > 128) begin : g_bad_levels
      $error("disp_select: LEVELS must lie in 8..128");
    end
    if (COST_W > 32 || COL_W <= D) begin : g_bad_width
      $error("disp_select: COST_W must be <= 32 and COL_W > log2(LEVELS)");
    end
  endgenerate

  // ---------------- column tracking ----------------
  logic [COL_W-1:0] col_cnt;
  logic [COL_W-1:0] cur_col;
  logic             in_fill;

  assign cur_col = in_sol ? '0 : col_cnt;
  assign in_fill = cur_col < COL_W'(LEVELS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) col_cnt <= '0;
    else if (in_valid) col_cnt <= (cur_col == '1) ? cur_col : cur_col + 1'b1;
  end

  // R7
  sol_restarts_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sol |=> col_cnt == COL_W'(1));
  // R7
  bubble_holds_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(col_cnt));

  dsel_ctrl_t ctrl_in;
  assign ctrl_in.vld = in_valid;
  assign ctrl_in.sol = in_valid & in_sol;
  assign ctrl_in.eol = in_valid & in_eol;
  assign ctrl_in.zf  = in_fill;
  assign ctrl_in.thr = uniq_thr;

  // ---------------- stage A: winner search ----------------
  logic [COST_W-1:0] win_min;
  logic [IW-1:0]     win_idx;
  logic [VEC_W-1:0]  costs_a;
  dsel_ctrl_t        ctrl_a;

  dsel_min_tree #(.N(LEVELS), .W(COST_W), .IW(IW)) u_tree_win (
    .clk(clk), .rst_n(rst_n), .vals_i(in_costs), .min_o(win_min), .idx_o(win_idx));

  dsel_delay #(.W(VEC_W), .DEPTH(D)) u_dly_cost (
    .clk(clk), .rst_n(rst_n), .d_i(in_costs), .q_o(costs_a));

  dsel_delay #(.W(CTRL_W), .DEPTH(D)) u_dly_ctrl_a (
    .clk(clk), .rst_n(rst_n), .d_i(ctrl_in), .q_o(ctrl_a));

  // R1
  win_matches_cost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_a.vld |-> costs_a[win_idx*COST_W +: COST_W] == win_min);

  // ---------------- stage M: mask the winner's neighbourhood ----------------
  logic [VEC_W-1:0]  masked_a;
  logic [VEC_W-1:0]  masked_m;
  logic [COST_W-1:0] min_m;
  logic [IW-1:0]     idx_m;
  dsel_ctrl_t        ctrl_m;

  generate
    for (genvar g = 0; g < LEVELS; g++) begin : g_mask
      assign masked_a[g*COST_W +: COST_W] = is_near(8'(g), 8'(win_idx)) ?
        {COST_W{1'b1}} : costs_a[g*COST_W +: COST_W];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      masked_m <= '0;
      min_m    <= '0;
      idx_m    <= '0;
      ctrl_m   <= '0;
    end else begin
      masked_m <= masked_a;
      min_m    <= win_min;
      idx_m    <= win_idx;
      ctrl_m   <= ctrl_a;
    end
  end

  // ---------------- stage B: runner-up search ----------------
  logic [COST_W-1:0]    run_min;
  logic [IW-1:0]        run_idx;
  logic [COST_W+IW-1:0] win_pack_b;
  logic [COST_W-1:0]    min_b;
  logic [IW-1:0]        idx_b;
  dsel_ctrl_t           ctrl_b;
  logic                 pass_b;

  dsel_min_tree #(.N(LEVELS), .W(COST_W), .IW(IW)) u_tree_run (
    .clk(clk), .rst_n(rst_n), .vals_i(masked_m), .min_o(run_min), .idx_o(run_idx));

  dsel_delay #(.W(COST_W+IW), .DEPTH(D)) u_dly_win (
    .clk(clk), .rst_n(rst_n), .d_i({min_m, idx_m}), .q_o(win_pack_b));

  dsel_delay #(.W(CTRL_W), .DEPTH(D)) u_dly_ctrl_b (
    .clk(clk), .rst_n(rst_n), .d_i(ctrl_m), .q_o(ctrl_b));

  assign {min_b, idx_b} = win_pack_b;
  assign pass_b = uniq_ok(32'(min_b), 32'(run_min), ctrl_b.thr);

  // R3
  runner_far_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_b.vld && run_min != {COST_W{1'b1}} |->
      (run_idx > idx_b + 1'b1) || (idx_b > run_idx + 1'b1));

  // ---------------- output register ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_sol     <= 1'b0;
      out_eol     <= 1'b0;
      out_disp    <= '0;
      out_invalid <= 1'b0;
    end else begin
      out_valid <= ctrl_b.vld;
      out_sol   <= ctrl_b.sol;
      out_eol   <= ctrl_b.eol;
      if (ctrl_b.zf) begin
        out_disp    <= '0;
        out_invalid <= 1'b0;
      end else if (pass_b) begin
        out_disp    <= idx_b;
        out_invalid <= 1'b0;
      end else begin
        out_disp    <= '1;
        out_invalid <= 1'b1;
      end
    end
  end

  // R5
  invalid_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_invalid |-> out_disp == '1);
  // R8
  flags_need_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sol || out_eol) |-> out_valid);

endmodule

// File: tb/disp_select_tb.sv
module disp_select_tb;

  localparam int LV  = 16;
  localparam int CW  = 12;
  localparam int DW  = $clog2(LV) + 1;
  localparam int LAT = 2 * $clog2(LV) + 2;

  logic             clk;
  logic             rst_n;
  logic             in_valid, in_sol, in_eol;
  logic [LV*CW-1:0] in_costs;
  logic [6:0]       uniq_thr;
  logic             out_valid, out_sol, out_eol, out_invalid;
  logic [DW-1:0]    out_disp;

  disp_select #(.LEVELS(LV), .COST_W(CW), .COL_W(10)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sol(in_sol), .in_eol(in_eol),
    .in_costs(in_costs), .uniq_thr(uniq_thr), .out_valid(out_valid), .out_sol(out_sol),
    .out_eol(out_eol), .out_disp(out_disp), .out_invalid(out_invalid));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct {
    bit    sol;
    bit    eol;
    bit    inv;
    int    disp;
    string tag;
  } exp_t;

  exp_t q[$];
  int   cst [LV];
  int   col;
  int   n_chk;
  int   n_err;
  bit   done;

  function automatic void model(input int c[LV], input int thr, output int disp, output bit inv);
    int  w, sec, u;
    bit  ok;
    w = 0;
    for (int i = 1; i < LV; i++) if (c[i] < c[w]) w = i;
    sec = 1 << 30;
    for (int i = 0; i < LV; i++)
      if ((i < w - 1 || i > w + 1) && c[i] < sec) sec = c[i];
    u  = (thr > 100) ? 100 : thr;
    ok = longint'(c[w]) * (100 + u) < longint'(sec) * 100;
    disp = ok ? w : (1 << DW) - 1;
    inv  = !ok;
  endfunction

  task automatic check(input bit cond, input string tag, input string what, input int act, input int expv);
    n_chk++;
    if (!cond) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  task automatic fill_all(input int v);
    for (int i = 0; i < LV; i++) cst[i] = v;
  endtask

  task automatic send(input bit sol, input bit eol, input int thr, input string tag);
    exp_t e;
    int   d;
    bit   iv;
    @(negedge clk);
    for (int i = 0; i < LV; i++) in_costs[i*CW +: CW] = CW'(cst[i]);
    in_valid = 1'b1;
    in_sol   = sol;
    in_eol   = eol;
    uniq_thr = 7'(thr);
    if (sol) col = 0;
    model(cst, thr, d, iv);
    e.sol = sol;
    e.eol = eol;
    if (col < LV) begin
      e.disp = 0;
      e.inv  = 1'b0;
      e.tag  = "R6";
    end else begin
      e.disp = d;
      e.inv  = iv;
      e.tag  = tag;
    end
    col++;
    q.push_back(e);
  endtask

  // bubbles carry random data that must be ignored
  task automatic gap(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sol   = 1'b0;
      in_eol   = 1'b0;
      for (int i = 0; i < LV; i++) in_costs[i*CW +: CW] = CW'($urandom % 4096);
      uniq_thr = 7'($urandom % 128);
    end
  endtask

  task automatic rand_costs();
    for (int i = 0; i < LV; i++) cst[i] = 200 + $urandom % 824;
    if ($urandom % 2 == 0) cst[$urandom % LV] = $urandom % 150;
  endtask

  // output monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (q.size() == 0) begin
        check(1'b0, "R8", "unexpected output beat", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(out_disp == DW'(e.disp) && out_invalid == e.inv &&
              out_sol == e.sol && out_eol == e.eol, e.tag,
              "pixel {sol,eol,inv,disp}",
              int'({out_sol, out_eol, out_invalid, out_disp}),
              int'({e.sol, e.eol, e.inv, DW'(e.disp)}));
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R8 watchdog expired: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = 20240611;
    void'($urandom(seed));
    n_chk = 0; n_err = 0; done = 0; col = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
    in_costs = '0; uniq_thr = 7'd5;
    repeat (3) @(negedge clk);
    // R9
    check(out_valid == 0 && out_sol == 0 && out_eol == 0 && out_disp == 0 && out_invalid == 0,
          "R9", "outputs in reset", int'({out_valid, out_disp}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8: latency of a single beat
    fill_all(300);
    send(1'b1, 1'b1, 5, "R8");
    @(negedge clk); in_valid = 1'b0; in_sol = 1'b0; in_eol = 1'b0;
    repeat (LAT - 2) @(negedge clk);
    check(out_valid == 1'b0, "R8", "valid one cycle early", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R8", "valid at latency", int'(out_valid), 1);
    gap(3);

    // directed row: fill columns with bubbles, then corner cases
    for (int c = 0; c < LV; c++) begin
      fill_all(400);
      cst[c % LV] = 3;
      if (c == 5) fill_all(50);     // R6: would be unreliable but sits in fill zone
      send(c == 0, 1'b0, 5, "R6");
      if (c % 4 == 1) gap(2);       // R7: bubbles do not advance the column
    end
    fill_all(500); cst[9] = 5;
    send(1'b0, 1'b0, 5, "R1");      // R1: clear minimum at level 9 -> 9
    fill_all(500); cst[LV-1] = 5;
    send(1'b0, 1'b0, 5, "R1");      // R1: last level -> 15
    fill_all(500); cst[3] = 7; cst[4] = 7;
    send(1'b0, 1'b0, 5, "R2");      // R2: tie 3/4 -> 3, 4 excluded so passes
    fill_all(22); cst[10] = 20; cst[9] = 21; cst[11] = 21;
    send(1'b0, 1'b0, 5, "R3");      // R3: neighbours excluded -> 10 passes
    fill_all(15); cst[2] = 10;
    send(1'b0, 1'b0, 0, "R4");      // R4: 1000 < 1500 pass
    send(1'b0, 1'b0, 49, "R4");     // R4: 1490 < 1500 pass
    send(1'b0, 1'b0, 50, "R5");     // R4/R5: 1500 !< 1500 -> invalid
    send(1'b0, 1'b0, 120, "R4");    // R4: clamped 100 -> invalid
    fill_all(21); cst[2] = 10;
    send(1'b0, 1'b0, 127, "R4");    // R4: clamp gives 2000 < 2100 pass
    fill_all(77);
    send(1'b0, 1'b1, 5, "R5");      // R5: flat costs -> invalid code
    gap(4);

    // second row restarts the column count (R7)
    for (int c = 0; c < LV + 4; c++) begin
      fill_all(600); cst[(c * 5) % LV] = 11;
      send(c == 0, c == LV + 3, 5, "R7");
    end
    gap(2);

    // random rows
    for (int r = 0; r < 4; r++) begin
      for (int p = 0; p < 40; p++) begin
        rand_costs();
        send(p == 0, p == 39, $urandom % 128, "R4");
        if ($urandom % 3 == 0) gap(1 + $urandom % 3);
      end
      gap(2);
    end

    gap(LAT + 3);
    // R8: every input beat produced exactly one output beat
    check(q.size() == 0, "R8", "beats still pending", q.size(), 0);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule